// File: doc/BRIEF.md
# Completion Queue Poster with Phase Tag

This block writes completion entries into circular completion queues that live in host memory. It keeps the state of each queue inside the controller: base address, slot count, tail, head and the current phase value. Each accepted completion record carries a command identifier, the ID of the originating submission queue, that queue's head and a status code. For each record the block emits one 16-byte memory write. The write goes to the queue's tail slot and carries the queue's current phase bit.

The phase bit inverts every time the tail wraps past the last slot. The host can therefore spot fresh entries by comparing phase bits in memory, without reading any controller register. The host frees entries by writing a new head index through a doorbell. A doorbell value that is out of range, or that points past the entries actually posted, is dropped and flagged. When the target queue has no free slot, the block holds the record source off by lowering ready.

Top module: `cq_poster`

## Requirements
- R1: After reset no queue exists: `rec_ready` is 0, `wr_valid` is 0 and `db_err` is 0.
- R2: A create command (`cfg_create`) sets the queue's base to `cfg_base` and its slot count to `cfg_last`+1. It also resets tail and head to 0 and sets the phase to 1, so the first entry goes to the base address with phase 1.
- R3: A record accepted on a clock edge (`rec_valid` and `rec_ready` both 1) produces exactly one cycle of `wr_valid` after that edge. The write address is base + tail*16. Without an acceptance, `wr_valid` is 0.
- R4: The write payload is laid out as follows: bits 63:0 are zero, 79:64 hold the submission queue head, 95:80 hold the submission queue ID, 111:96 hold the command identifier, bit 112 holds the phase, and 127:113 hold the status.
- R5: Each posted entry advances the tail by one slot. After the last slot (index `cfg_last`) the tail returns to slot 0.
- R6: The phase value of a queue inverts each time its tail wraps from the last slot to slot 0. Entries posted after the wrap carry the inverted phase.
- R7: A queue is full when (tail+1) mod size equals head. While the queue is full, `rec_ready` is 0 for records aimed at it and no write is produced.
- R8: A doorbell whose head value lies within the posted region, counting from the old head up to and including the tail, updates the head. The freed slots can then be posted again, and `db_err` stays 0.
- R9: A doorbell whose head value exceeds the last slot index, or that is aimed at a queue never created, is ignored. `db_err` is 1 for exactly the cycle after it.
- R10: A doorbell whose head value lies beyond the current tail, measured from the old head, is ignored and raises `db_err` in the following cycle.
- R11: Queues are independent. Posting to one queue does not change the tail or phase of another.
- R12: Creating a queue again discards its old state. Its tail and head return to 0 and its phase returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_create | input | 1 | Create (or re-create) a queue |
| cfg_qid | input | QID_W | Queue being created |
| cfg_base | input | ADDR_W | Byte base address of the queue, 16-byte aligned |
| cfg_last | input | IDX_W | Slot count minus one (at least 1) |
| rec_valid | input | 1 | Completion record present |
| rec_ready | output | 1 | Target queue exists and has a free slot |
| rec_qid | input | QID_W | Target completion queue |
| rec_cid | input | 16 | Command identifier |
| rec_sqid | input | 16 | Originating submission queue ID |
| rec_sqhd | input | 16 | Submission queue head to report |
| rec_status | input | 15 | Completion status |
| db_valid | input | 1 | Head doorbell write |
| db_qid | input | QID_W | Queue the doorbell addresses |
| db_head | input | IDX_W | New head index |
| db_err | output | 1 | Rejected doorbell, one cycle later |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Byte address of the entry |
| wr_data | output | 128 | Entry payload |

## Verification
The write for an accepted record is due in the cycle after the accepting edge. The bench drives the record at a falling edge, queues the expected address and payload before the next rising edge, and a monitor compares the write at the falling edge that follows. Any write that appears with nothing queued counts as a failure, which is how blocked and full posts are covered. `db_err` also answers one cycle after the doorbell edge, so the doorbell task releases the doorbell at the next falling edge and samples `db_err` there. `rec_ready` is combinational on the current queue state, so the bench reads it shortly after it drives the record.

// File: rtl/cqp_pkg.sv
package cqp_pkg;
   localparam int ENTRY_BYTES = 16;
   localparam int ENTRY_W     = 8 * ENTRY_BYTES;
   localparam int OFS_SHIFT   = $clog2(ENTRY_BYTES);

   typedef struct packed {
      logic [14:0] status;
      logic        phase;
      logic [15:0] cid;
      logic [15:0] sqid;
      logic [15:0] sqhd;
      logic [63:0] rsvd;
   } cq_entry_t;
endpackage

// File: rtl/cq_qslot.sv
module cq_qslot #(
   parameter int IDX_W  = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              create,
   input  logic [ADDR_W-1:0] cr_base,
   input  logic [IDX_W-1:0]  cr_last,
   input  logic              post,
   input  logic              db_apply,
   input  logic [IDX_W-1:0]  db_head,
   output logic              en,
   output logic [ADDR_W-1:0] base,
   output logic [IDX_W-1:0]  last,
   output logic [IDX_W-1:0]  tail,
   output logic [IDX_W-1:0]  head,
   output logic              phase,
   output logic              full
);
   logic             wrap;
   logic [IDX_W-1:0] tail_nx;

   always_comb begin
      wrap    = (tail == last);
      tail_nx = wrap ? '0 : tail + 1'b1;
      full    = (tail_nx == head);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         base  <= '0;
         last  <= '0;
         tail  <= '0;
         head  <= '0;
         phase <= 1'b1;
      end else if (create) begin
         en    <= 1'b1;
         base  <= cr_base;
         last  <= cr_last;
         tail  <= '0;
         head  <= '0;
         phase <= 1'b1;
      end else begin
         if (post) begin
            tail <= tail_nx;
            if (wrap) phase <= ~phase;
         end
         if (db_apply) head <= db_head;
      end
   end
endmodule

// File: rtl/cq_db_check.sv
module cq_db_check #(
   parameter int IDX_W = 8
) (
   input  logic             en,
   input  logic [IDX_W-1:0] last,
   input  logic [IDX_W-1:0] tail,
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] new_head,
   output logic             ok
);
   localparam int CW = IDX_W + 1;
   logic [CW-1:0] size, used, adv;

   always_comb begin
      size = {1'b0, last} + 1'b1;
      used = (tail >= head) ? CW'(tail) - CW'(head) : CW'(tail) + size - CW'(head);
      adv  = (new_head >= head) ? CW'(new_head) - CW'(head)
                                : CW'(new_head) + size - CW'(head);
      ok   = en && (new_head <= last) && (adv <= used);
   end
endmodule

// File: rtl/cq_entry_fmt.sv
module cq_entry_fmt
   import cqp_pkg::*;
(
   input  logic        phase,
   input  logic [15:0] cid,
   input  logic [15:0] sqid,
   input  logic [15:0] sqhd,
   input  logic [14:0] status,
   output cq_entry_t   entry
);
   always_comb begin
      entry.status = status;
      entry.phase  = phase;
      entry.cid    = cid;
      entry.sqid   = sqid;
      entry.sqhd   = sqhd;
      entry.rsvd   = '0;
   end
endmodule

// File: rtl/cq_poster.sv
module cq_poster
   import cqp_pkg::*;
#(
   parameter int NUM_Q  = 4,
   parameter int IDX_W  = 8,
   parameter int ADDR_W = 32,
   parameter int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_create,
   input  logic [QID_W-1:0]   cfg_qid,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [IDX_W-1:0]   cfg_last,
   input  logic               rec_valid,
   output logic               rec_ready,
   input  logic [QID_W-1:0]   rec_qid,
   input  logic [15:0]        rec_cid,
   input  logic [15:0]        rec_sqid,
   input  logic [15:0]        rec_sqhd,
   input  logic [14:0]        rec_status,
   input  logic               db_valid,
   input  logic [QID_W-1:0]   db_qid,
   input  logic [IDX_W-1:0]   db_head,
   output logic               db_err,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [ENTRY_W-1:0] wr_data
);
   localparam int PAD_W = ADDR_W - IDX_W - OFS_SHIFT;

   generate
      if (NUM_Q < 1 || (1 << QID_W) < NUM_Q)
         $error("cq_poster: NUM_Q/QID_W mismatch");
      if (IDX_W < 1 || PAD_W < 0)
         $error("cq_poster: ADDR_W too small for IDX_W slots");
   endgenerate

   logic              en_q    [NUM_Q];
   logic [ADDR_W-1:0] base_q  [NUM_Q];
   logic [IDX_W-1:0]  last_q  [NUM_Q];
   logic [IDX_W-1:0]  tail_q  [NUM_Q];
   logic [IDX_W-1:0]  head_q  [NUM_Q];
   logic              phase_q [NUM_Q];
   logic              full_q  [NUM_Q];

   logic accept, db_ok;
   logic [IDX_W-1:0] db_last;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_Q; gi++) begin : g_q
         cq_qslot #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .create  (cfg_create && cfg_qid == QID_W'(gi)),
            .cr_base (cfg_base),
            .cr_last (cfg_last),
            .post    (accept && rec_qid == QID_W'(gi)),
            .db_apply(db_valid && db_ok && db_qid == QID_W'(gi)),
            .db_head (db_head),
            .en      (en_q[gi]),
            .base    (base_q[gi]),
            .last    (last_q[gi]),
            .tail    (tail_q[gi]),
            .head    (head_q[gi]),
            .phase   (phase_q[gi]),
            .full    (full_q[gi])
         );
      end
   endgenerate

   assign rec_ready = en_q[rec_qid] && !full_q[rec_qid];
   assign accept    = rec_valid && rec_ready;
   assign db_last   = last_q[db_qid];

   cq_db_check #(.IDX_W(IDX_W)) u_dbchk (
      .en      (en_q[db_qid]),
      .last    (db_last),
      .tail    (tail_q[db_qid]),
      .head    (head_q[db_qid]),
      .new_head(db_head),
      .ok      (db_ok)
   );

   cq_entry_t entry;
   cq_entry_fmt u_fmt (
      .phase (phase_q[rec_qid]),
      .cid   (rec_cid),
      .sqid  (rec_sqid),
      .sqhd  (rec_sqhd),
      .status(rec_status),
      .entry (entry)
   );

   logic [ADDR_W-1:0] slot_ofs;
   generate
      if (PAD_W > 0) begin : g_pad
         assign slot_ofs = {{PAD_W{1'b0}}, tail_q[rec_qid], {OFS_SHIFT{1'b0}}};
      end else begin : g_nopad
         assign slot_ofs = {tail_q[rec_qid], {OFS_SHIFT{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         db_err   <= 1'b0;
      end else begin
         wr_valid <= accept;
         db_err   <= db_valid && !db_ok;
         if (accept) begin
            wr_addr <= base_q[rec_qid] + slot_ofs;
            wr_data <= entry;
         end
      end
   end
endmodule

// File: rtl/cq_poster_chk.sv
module cq_poster_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rec_valid,
   input logic             rec_ready,
   input logic [15:0]      rec_cid,
   input logic [15:0]      rec_sqid,
   input logic             db_valid,
   input logic [IDX_W-1:0] db_head,
   input logic [IDX_W-1:0] db_last,
   input logic             db_err,
   input logic             wr_valid,
   input logic [127:0]     wr_data
);
   AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_ready) |=> wr_valid); // R3
   AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rec_valid && rec_ready) |=> !wr_valid); // R7
   AST_CID_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_ready) |=> wr_data[111:96] == $past(rec_cid)); // R4
   AST_SQID_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_ready) |=> wr_data[95:80] == $past(rec_sqid)); // R4
   AST_DB_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (db_valid && db_head > db_last) |=> db_err); // R9
   AST_ERR_NEEDS_DB: assert property (@(posedge clk) disable iff (!rst_n)
      !db_valid |=> !db_err); // R9
endmodule

bind cq_poster cq_poster_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rec_valid(rec_valid),
   .rec_ready(rec_ready),
   .rec_cid  (rec_cid),
   .rec_sqid (rec_sqid),
   .db_valid (db_valid),
   .db_head  (db_head),
   .db_last  (db_last),
   .db_err   (db_err),
   .wr_valid (wr_valid),
   .wr_data  (wr_data)
);

// File: tb/cq_poster_test.sv
`timescale 1ns/1ps
module cq_poster_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_create = 1'b0;
   logic [1:0]   cfg_qid = '0;
   logic [31:0]  cfg_base = '0;
   logic [7:0]   cfg_last = '0;
   logic         rec_valid = 1'b0;
   logic         rec_ready;
   logic [1:0]   rec_qid = '0;
   logic [15:0]  rec_cid = '0, rec_sqid = '0, rec_sqhd = '0;
   logic [14:0]  rec_status = '0;
   logic         db_valid = 1'b0;
   logic [1:0]   db_qid = '0;
   logic [7:0]   db_head = '0;
   logic         db_err, wr_valid;
   logic [31:0]  wr_addr;
   logic [127:0] wr_data;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   int          m_tail [4], m_head [4], m_last [4];
   bit          m_phase[4];
   logic [31:0] m_base [4];

   logic [159:0] exp_q[$];
   string        tag_q[$];

   always #10 clk = ~clk;

   cq_poster #(.NUM_Q(4), .IDX_W(8), .ADDR_W(32)) uut (.*);

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: compare each write against the scoreboard
   always @(negedge clk) begin
      if (rst_n && wr_valid && !done) begin
         n_run++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected write: actual %h@%h expected none", wr_data, wr_addr);
         end else begin
            logic [159:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({wr_addr, wr_data} !== e) begin
               n_fail++;
               $display("FAIL %s write: actual %h@%h expected %h@%h",
                        t, wr_data, wr_addr, e[127:0], e[159:128]);
            end
         end
      end
   end

   task automatic create(int q, logic [31:0] base, int last);
      @(negedge clk);
      cfg_create = 1'b1; cfg_qid = 2'(q); cfg_base = base; cfg_last = 8'(last);
      @(negedge clk);
      cfg_create = 1'b0;
      m_base[q] = base; m_last[q] = last; m_tail[q] = 0; m_head[q] = 0; m_phase[q] = 1'b1;
   endtask

   task automatic post(int q, logic [15:0] cid, logic [15:0] sqid, string tag);
      int nxt;
      @(negedge clk);
      rec_valid = 1'b1; rec_qid = 2'(q); rec_cid = cid; rec_sqid = sqid;
      rec_sqhd = cid ^ 16'h5a5a; rec_status = 15'(cid * 3);
      #1;
      nxt = (m_tail[q] == m_last[q]) ? 0 : m_tail[q] + 1;
      if (nxt == m_head[q]) begin
         chk(rec_ready == 1'b0, "R7", "ready while full", rec_ready, 0);
      end else begin
         chk(rec_ready == 1'b1, tag, "ready", rec_ready, 1);
         exp_q.push_back({m_base[q] + 32'(m_tail[q] * 16),
                          rec_status, m_phase[q], cid, sqid, rec_sqhd, 64'h0});
         tag_q.push_back(tag);
         if (m_tail[q] == m_last[q]) m_phase[q] = ~m_phase[q];
         m_tail[q] = nxt;
      end
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   task automatic ring(int q, int h, bit exp_err, string tag);
      @(negedge clk);
      db_valid = 1'b1; db_qid = 2'(q); db_head = 8'(h);
      @(negedge clk);
      db_valid = 1'b0;
      chk(db_err == exp_err, tag, "db_err", db_err, exp_err);
      if (!exp_err) m_head[q] = h;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rec_valid = 1'b1; #1;
      chk(rec_ready == 1'b0, "R1", "ready after reset", rec_ready, 0);
      rec_valid = 1'b0;
      chk(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);
      chk(db_err == 1'b0, "R1", "db_err after reset", db_err, 0);
      @(negedge clk); rst_n = 1'b1;

      create(0, 32'h0000_1000, 3);
      create(1, 32'h0000_8000, 2);
      post(0, 16'h0011, 16'h0001, "R2");          // slot 0, phase 1
      post(0, 16'h0012, 16'h0002, "R3/R4");       // slot 1
      post(0, 16'h0013, 16'h0003, "R5");          // slot 2
      post(0, 16'h0014, 16'h0004, "R7");          // full: blocked
      post(1, 16'h0101, 16'h0007, "R11");         // other queue
      ring(0, 9, 1'b1, "R9");                     // out of range
      ring(0, 2, 1'b0, "R8");                     // frees slots 0,1
      post(0, 16'h0015, 16'h0005, "R5");          // slot 3, then wrap
      ring(0, 1, 1'b1, "R10");                    // beyond tail
      post(0, 16'h0016, 16'h0006, "R6");          // slot 0, phase 0
      post(0, 16'h0017, 16'h0008, "R7");          // full again
      ring(0, 1, 1'b0, "R8");                     // drain to tail
      post(0, 16'h0018, 16'h0009, "R8");          // slot 1, phase 0
      post(1, 16'h0102, 16'h000a, "R11");         // q1 slot 1, phase 1
      ring(2, 0, 1'b1, "R9");                     // queue never created
      create(0, 32'h0000_2000, 1);
      post(0, 16'h0021, 16'h000b, "R12");         // fresh: base, phase 1
      post(0, 16'h0022, 16'h000c, "R7");          // two-slot queue full

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "writes outstanding", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule